// File: doc/BRIEF.md
# Parallel Video Byte Port Formatter

This block drives an 8-bit parallel video port from a stream of internal pixel words or from a stream of compressed bytes. Each byte it puts out comes with a one-cycle qualifier (`vid_en`), and the qualifier is never raised during blanking. Pixel frames are packed into one of four byte formats: luma/chroma interleaved 4:2:2, 16-bit 5-6-5 RGB, 16-bit 4-4-4 RGB or 8-bit 3-3-2 RGB. The byte order of the two RGB 16-bit formats can be selected. Frames are delimited in one of two ways. The first uses separate horizontal and vertical sync outputs. The second uses ITU-R 656 style timing codes embedded in the byte stream. A compressed stream has no lines: it goes out as one long line, with both sync outputs held high together.

The block is built around a state machine with six states:
- `S_IDLE` latches the configuration. It then either begins a frame (`S_IDLE -> S_HBLANK`) or, in stream mode, waits for the first byte (`S_IDLE -> S_STREAM`).
- `S_HBLANK` counts the horizontal blanking. From there it goes to `S_SAV` in embedded mode, to `S_ACTIVE` on a picture line, or back to `S_HBLANK` at the end of a blanking line in separate-sync mode.
- `S_SAV` sends the start code. It is followed by `S_ACTIVE`, or by `S_EAV` on a blanking line.
- `S_ACTIVE` pulls pixels and sends their bytes. After the last pixel of the line it goes to `S_EAV` in embedded mode and to `S_HBLANK` otherwise.
- `S_EAV` sends the end code and then returns to `S_HBLANK`.
- `S_STREAM` passes compressed bytes through and returns to `S_IDLE` after the byte flagged last.

Every line end that closes the frame goes back to `S_IDLE` instead. A frame is `cfg_vblank` blanking lines followed by `cfg_lines` picture lines, and each line opens with `cfg_hblank` blanking cycles. A blanking line has no pixel area.

Top module: `vid_byte_port`

## Requirements
- R1: With `cfg_fmt`=0 (4:2:2), each pixel word sends `pix_data[15:8]` (chroma) and then `pix_data[7:0]` (luma). A source that alternates U and V between pixels therefore produces the byte order U, Y, V, Y. The swap bit does not affect this format.
- R2: With `cfg_fmt`=1, a pixel (R in `pix_data[23:16]`, G in `[15:8]`, B in `[7:0]`) becomes the word {R[7:3],G[7:2],B[7:3]}. The low byte goes first when `cfg_swap`=0 and the high byte goes first when `cfg_swap`=1.
- R3: With `cfg_fmt`=2, a pixel becomes the word {4'h0,R[7:4],G[7:4],B[7:4]}, ordered by `cfg_swap` as in R2.
- R4: With `cfg_fmt`=3, each pixel sends exactly one byte {R[7:5],G[7:5],B[7:6]}.
- R5: In separate-sync mode (`cfg_embed`=0), `vid_vs` is low during the blanking lines and high through the picture lines. `vid_hs` is high only over the pixel area of a picture line.
- R6: In embedded mode, each line is `cfg_hblank` blanking cycles, the code FF 00 00 XY, the pixel area on picture lines only, and the code FF 00 00 XY again. XY = {1,F,V,H,V^H,F^H,F^V,F^V^H} with F=0, V=1 on blanking lines, H=0 for the start code and H=1 for the end code. Both sync outputs stay low.
- R7: `vid_en` is high only for pixel bytes, code bytes and stream bytes. On every cycle with `vid_en` low, `vid_data` equals the blanking value 8'h10.
- R8: In stream mode (`cfg_stream`=1), bytes from `pix_data[7:0]` are sent unchanged and in order. `vid_hs` and `vid_vs` rise together with the first byte and stay high together until the byte flagged by `pix_last` has been sent.
- R9: Each picture line carries exactly `cfg_pix` pixels, and the first pixel byte of a line follows exactly `cfg_hblank` blanking cycles.
- R10: When `pix_valid` is low in the pixel area, no byte is qualified. No pixel is lost or repeated, and the line still ends after `cfg_pix` pixels.
- R11: During reset, `vid_en`, `vid_hs` and `vid_vs` are low and `vid_data` holds the blanking value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_fmt | input | 2 | Byte format: 0 4:2:2, 1 RGB 5-6-5, 2 RGB 4-4-4, 3 RGB 3-3-2 |
| cfg_swap | input | 1 | 1 sends the high byte first in 16-bit RGB formats |
| cfg_embed | input | 1 | 1 selects embedded timing codes instead of sync outputs |
| cfg_stream | input | 1 | 1 selects compressed-stream mode |
| cfg_hblank | input | CNT_W | Blanking cycles at the start of each line |
| cfg_vblank | input | CNT_W | Blanking lines at the start of each frame |
| cfg_pix | input | CNT_W | Pixels per picture line (at least 1) |
| cfg_lines | input | CNT_W | Picture lines per frame (at least 1) |
| pix_valid | input | 1 | Source offers a pixel word or stream byte |
| pix_last | input | 1 | Marks the final byte of a compressed stream |
| pix_data | input | 24 | Pixel word or stream byte (bits 7:0) |
| pix_ready | output | 1 | Block takes the offered word this cycle |
| vid_data | output | 8 | Output byte |
| vid_en | output | 1 | Qualifying pulse for `vid_data` |
| vid_hs | output | 1 | Horizontal sync / line valid |
| vid_vs | output | 1 | Vertical sync / frame valid |

## Verification
The assertions take for granted that the configuration changes only while the block is idle or in reset, and that `cfg_pix` and `cfg_lines` are at least 1. They also assume that `pix_last` is meaningful only in stream mode and that the source never withdraws a word before the block accepts it. The bench changes the configuration only while reset is held. It offers words through a source that advances exactly on a cycle where both `pix_valid` and `pix_ready` are high. It uses small nonzero line and frame sizes, and creates stalls by dropping `pix_valid` on a fixed cycle pattern.

// File: rtl/vof_pkg.sv
package vof_pkg;

    localparam int VOF_PIX_W = 24;

    typedef enum logic [1:0] {
        FMT_UYVY   = 2'd0,
        FMT_RGB565 = 2'd1,
        FMT_RGB444 = 2'd2,
        FMT_RGB332 = 2'd3
    } vof_fmt_e;

    typedef enum logic [2:0] {
        S_IDLE   = 3'd0,
        S_HBLANK = 3'd1,
        S_SAV    = 3'd2,
        S_ACTIVE = 3'd3,
        S_EAV    = 3'd4,
        S_STREAM = 3'd5
    } vof_state_e;

endpackage

// File: rtl/vof_packer.sv
module vof_packer
    import vof_pkg::*;
(
    input  vof_fmt_e               fmt,
    input  logic                   swap,
    input  logic [VOF_PIX_W-1:0]   pix,
    output logic [7:0]             first_b,
    output logic [7:0]             second_b,
    output logic                   two_bytes
);
    logic [7:0]  red, grn, blu;
    logic [15:0] word;
    logic        unused_low_red;

    assign red = pix[23:16];
    assign grn = pix[15:8];
    assign blu = pix[7:0];
    // low red bits feed no format
    assign unused_low_red = ^red[2:0];

    always_comb begin
        word      = 16'h0000;
        first_b   = 8'h00;
        second_b  = 8'h00;
        two_bytes = 1'b1;
        unique case (fmt)
            FMT_UYVY: begin
                first_b  = grn;
                second_b = blu;
            end
            FMT_RGB565, FMT_RGB444: begin
                if (fmt == FMT_RGB565)
                    word = {red[7:3], grn[7:2], blu[7:3]};
                else
                    word = {4'h0, red[7:4], grn[7:4], blu[7:4]};
                first_b  = swap ? word[15:8] : word[7:0];
                second_b = swap ? word[7:0]  : word[15:8];
            end
            FMT_RGB332: begin
                first_b   = {red[7:5], grn[7:5], blu[7:6]};
                two_bytes = 1'b0;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/vof_code_gen.sv
module vof_code_gen #(
    parameter logic FIELD = 1'b0
) (
    input  logic [1:0] idx,
    input  logic       vbit,
    input  logic       hbit,
    output logic [7:0] code
);
    logic [7:0] xy;

    assign xy = {1'b1, FIELD, vbit, hbit,
                 vbit ^ hbit, FIELD ^ hbit, FIELD ^ vbit, FIELD ^ vbit ^ hbit};

    always_comb begin
        unique case (idx)
            2'd0:    code = 8'hFF;
            2'd1:    code = 8'h00;
            2'd2:    code = 8'h00;
            default: code = xy;
        endcase
    end
endmodule

// File: rtl/vof_seq.sv
module vof_seq
    import vof_pkg::*;
#(
    parameter int         CNT_W      = 12,
    parameter logic [7:0] BLANK_BYTE = 8'h10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_fmt,
    input  logic              cfg_swap,
    input  logic              cfg_embed,
    input  logic              cfg_stream,
    input  logic [CNT_W-1:0]  cfg_hblank,
    input  logic [CNT_W-1:0]  cfg_vblank,
    input  logic [CNT_W-1:0]  cfg_pix,
    input  logic [CNT_W-1:0]  cfg_lines,
    input  logic              pix_valid,
    input  logic              pix_last,
    input  logic [7:0]        stream_byte,
    input  logic [7:0]        pk_first,
    input  logic [7:0]        pk_second,
    input  logic              pk_two,
    input  logic [7:0]        code_byte,
    output vof_fmt_e          fmt_q,
    output logic              swap_q,
    output logic [1:0]        code_idx,
    output logic              code_v,
    output logic              code_h,
    output logic              pix_ready,
    output logic [7:0]        vid_data,
    output logic              vid_en,
    output logic              vid_hs,
    output logic              vid_vs
);
    localparam int LN_W = CNT_W + 1;

    vof_state_e        state, state_n;
    logic              embed_q;
    logic [CNT_W-1:0]  hblank_q, vblank_q, pix_q, lines_q;
    logic [CNT_W-1:0]  cnt, pix_cnt;
    logic [LN_W-1:0]   line_cnt;
    logic              phase;
    logic [7:0]        hold;

    logic              accept, pix_done, last_pix, hb_done, code_done;
    logic              vblank_line, last_line, line_end;
    logic [7:0]        nx_data;
    logic              nx_en, nx_hs, nx_vs;

    // ---------------- event decode ----------------
    assign pix_ready   = (state == S_ACTIVE && !phase) || state == S_STREAM ||
                         (state == S_IDLE && cfg_stream);
    assign accept      = pix_ready && pix_valid;
    assign pix_done    = (state == S_ACTIVE) && (phase || (accept && !pk_two));
    assign last_pix    = pix_done && (pix_cnt == pix_q - 1'b1);
    assign hb_done     = (state == S_HBLANK) &&
                         ((LN_W'(cnt) + LN_W'(1)) >= LN_W'(hblank_q));
    assign code_done   = (code_idx == 2'd3);
    assign vblank_line = line_cnt < LN_W'(vblank_q);
    assign last_line   = line_cnt == (LN_W'(vblank_q) + LN_W'(lines_q) - LN_W'(1));
    assign line_end    = embed_q ? (state == S_EAV && code_done)
                                 : ((hb_done && vblank_line) || last_pix);
    assign code_v      = vblank_line;
    assign code_h      = (state == S_EAV);

    // ---------------- next state ----------------
    always_comb begin
        state_n = state;
        unique case (state)
            S_IDLE: begin
                if (!cfg_stream)                   state_n = S_HBLANK;
                else if (accept && !pix_last)      state_n = S_STREAM;
            end
            S_HBLANK: begin
                if (hb_done) begin
                    if (embed_q)                   state_n = S_SAV;
                    else if (!vblank_line)         state_n = S_ACTIVE;
                    else if (last_line)            state_n = S_IDLE;
                end
            end
            S_SAV: begin
                if (code_done)                     state_n = vblank_line ? S_EAV : S_ACTIVE;
            end
            S_ACTIVE: begin
                if (last_pix) begin
                    if (embed_q)                   state_n = S_EAV;
                    else if (last_line)            state_n = S_IDLE;
                    else                           state_n = S_HBLANK;
                end
            end
            S_EAV: begin
                if (code_done)                     state_n = last_line ? S_IDLE : S_HBLANK;
            end
            S_STREAM: begin
                if (accept && pix_last)            state_n = S_IDLE;
            end
            default:                               state_n = S_IDLE;
        endcase
    end

    // ---------------- state register and counters ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            fmt_q    <= FMT_UYVY;
            swap_q   <= 1'b0;
            embed_q  <= 1'b0;
            hblank_q <= '0;
            vblank_q <= '0;
            pix_q    <= '0;
            lines_q  <= '0;
            cnt      <= '0;
            pix_cnt  <= '0;
            line_cnt <= '0;
            code_idx <= 2'd0;
            phase    <= 1'b0;
            hold     <= 8'h00;
        end else begin
            state <= state_n;
            if (state == S_IDLE) begin
                fmt_q    <= vof_fmt_e'(cfg_fmt);
                swap_q   <= cfg_swap;
                embed_q  <= cfg_embed;
                hblank_q <= cfg_hblank;
                vblank_q <= cfg_vblank;
                pix_q    <= cfg_pix;
                lines_q  <= cfg_lines;
                pix_cnt  <= '0;
                line_cnt <= '0;
                phase    <= 1'b0;
            end
            if (line_end || state_n != state)
                cnt <= '0;
            else if (state == S_HBLANK)
                cnt <= cnt + 1'b1;
            if (state == S_SAV || state == S_EAV)
                code_idx <= code_idx + 2'd1;
            if (state == S_ACTIVE) begin
                if (phase)
                    phase <= 1'b0;
                else if (accept && pk_two) begin
                    phase <= 1'b1;
                    hold  <= pk_second;
                end
                if (pix_done)
                    pix_cnt <= last_pix ? '0 : pix_cnt + 1'b1;
            end
            if (line_end && state != S_IDLE)
                line_cnt <= last_line ? '0 : line_cnt + 1'b1;
        end
    end

    // ---------------- output decode ----------------
    always_comb begin
        nx_data = BLANK_BYTE;
        nx_en   = 1'b0;
        nx_hs   = 1'b0;
        nx_vs   = 1'b0;
        unique case (state)
            S_IDLE: begin
                if (cfg_stream && accept) begin
                    nx_data = stream_byte;
                    nx_en   = 1'b1;
                    nx_hs   = 1'b1;
                    nx_vs   = 1'b1;
                end
            end
            S_HBLANK: begin
                nx_vs = !embed_q && !vblank_line;
            end
            S_SAV, S_EAV: begin
                nx_data = code_byte;
                nx_en   = 1'b1;
            end
            S_ACTIVE: begin
                nx_hs = !embed_q;
                nx_vs = !embed_q;
                if (phase) begin
                    nx_data = hold;
                    nx_en   = 1'b1;
                end else if (accept) begin
                    nx_data = pk_first;
                    nx_en   = 1'b1;
                end
            end
            S_STREAM: begin
                nx_hs = 1'b1;
                nx_vs = 1'b1;
                if (accept) begin
                    nx_data = stream_byte;
                    nx_en   = 1'b1;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vid_data <= BLANK_BYTE;
            vid_en   <= 1'b0;
            vid_hs   <= 1'b0;
            vid_vs   <= 1'b0;
        end else begin
            vid_data <= nx_data;
            vid_en   <= nx_en;
            vid_hs   <= nx_hs;
            vid_vs   <= nx_vs;
        end
    end

    // ---------------- assertions ----------------
    // R8
    stream_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state == S_STREAM |-> (vid_hs && vid_vs));

    // R5
    hs_within_vs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vid_hs |-> vid_vs);

    // R6
    embed_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (embed_q && (state == S_SAV || state == S_ACTIVE || state == S_EAV))
        |-> (!vid_hs && !vid_vs));

    // R4
    single_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_ACTIVE && fmt_q == FMT_RGB332) |-> !phase);

    // R9
    pix_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state == S_ACTIVE |-> (pix_cnt < pix_q));

    // R7
    code_qualified_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state == S_SAV |=> vid_en);

endmodule

// File: rtl/vid_byte_port.sv
module vid_byte_port
    import vof_pkg::*;
#(
    parameter int         CNT_W      = 12,
    parameter logic [7:0] BLANK_BYTE = 8'h10
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [1:0]            cfg_fmt,
    input  logic                  cfg_swap,
    input  logic                  cfg_embed,
    input  logic                  cfg_stream,
    input  logic [CNT_W-1:0]      cfg_hblank,
    input  logic [CNT_W-1:0]      cfg_vblank,
    input  logic [CNT_W-1:0]      cfg_pix,
    input  logic [CNT_W-1:0]      cfg_lines,
    input  logic                  pix_valid,
    input  logic                  pix_last,
    input  logic [VOF_PIX_W-1:0]  pix_data,
    output logic                  pix_ready,
    output logic [7:0]            vid_data,
    output logic                  vid_en,
    output logic                  vid_hs,
    output logic                  vid_vs
);
    vof_fmt_e   fmt_q;
    logic       swap_q;
    logic [7:0] pk_first, pk_second, code_byte;
    logic       pk_two;
    logic [1:0] code_idx;
    logic       code_v, code_h;

    vof_packer u_pack (
        .fmt       (fmt_q),
        .swap      (swap_q),
        .pix       (pix_data),
        .first_b   (pk_first),
        .second_b  (pk_second),
        .two_bytes (pk_two)
    );

    vof_code_gen #(.FIELD(1'b0)) u_code (
        .idx  (code_idx),
        .vbit (code_v),
        .hbit (code_h),
        .code (code_byte)
    );

    vof_seq #(.CNT_W(CNT_W), .BLANK_BYTE(BLANK_BYTE)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_fmt     (cfg_fmt),
        .cfg_swap    (cfg_swap),
        .cfg_embed   (cfg_embed),
        .cfg_stream  (cfg_stream),
        .cfg_hblank  (cfg_hblank),
        .cfg_vblank  (cfg_vblank),
        .cfg_pix     (cfg_pix),
        .cfg_lines   (cfg_lines),
        .pix_valid   (pix_valid),
        .pix_last    (pix_last),
        .stream_byte (pix_data[7:0]),
        .pk_first    (pk_first),
        .pk_second   (pk_second),
        .pk_two      (pk_two),
        .code_byte   (code_byte),
        .fmt_q       (fmt_q),
        .swap_q      (swap_q),
        .code_idx    (code_idx),
        .code_v      (code_v),
        .code_h      (code_h),
        .pix_ready   (pix_ready),
        .vid_data    (vid_data),
        .vid_en      (vid_en),
        .vid_hs      (vid_hs),
        .vid_vs      (vid_vs)
    );
endmodule

// File: tb/sim_vid_byte_port.sv
module sim_vid_byte_port;
    localparam int         CW    = 12;
    localparam logic [7:0] BLANK = 8'h10;
    localparam int         HB    = 3;
    localparam int         NPIX  = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    cfg_fmt = 2'd0;
    logic          cfg_swap = 1'b0, cfg_embed = 1'b0, cfg_stream = 1'b0;
    logic [CW-1:0] cfg_hblank = CW'(HB), cfg_vblank = CW'(1);
    logic [CW-1:0] cfg_pix = CW'(NPIX), cfg_lines = CW'(2);
    logic          pix_valid = 1'b0, pix_last = 1'b0;
    logic [23:0]   pix_data = 24'h0;
    logic          pix_ready;
    logic [7:0]    vid_data;
    logic          vid_en, vid_hs, vid_vs;

    int n_chk = 0, n_fail = 0;

    vid_byte_port #(.CNT_W(CW), .BLANK_BYTE(BLANK)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_fmt(cfg_fmt), .cfg_swap(cfg_swap),
        .cfg_embed(cfg_embed), .cfg_stream(cfg_stream), .cfg_hblank(cfg_hblank),
        .cfg_vblank(cfg_vblank), .cfg_pix(cfg_pix), .cfg_lines(cfg_lines),
        .pix_valid(pix_valid), .pix_last(pix_last), .pix_data(pix_data),
        .pix_ready(pix_ready), .vid_data(vid_data), .vid_en(vid_en),
        .vid_hs(vid_hs), .vid_vs(vid_vs)
    );

    always #10 clk = ~clk;

    function automatic logic [23:0] pix_at(int i);
        logic [7:0] r, g, b;
        r = 8'(i * 37 + 5);
        g = 8'(i * 91 + 17);
        b = 8'(i * 53 + 200);
        return {r, g, b};
    endfunction

    // ---------------- source ----------------
    logic src_on = 1'b0, stall_en = 1'b0, took = 1'b0;
    int   src_idx = 0, src_len = 1000000, cyc = 0;

    always @(negedge clk) begin
        cyc++;
        if (!rst_n) begin
            src_idx = 0;
            took    = 1'b0;
        end else if (took) begin
            src_idx++;
        end
        pix_valid = src_on && (src_idx < src_len) && !(stall_en && (cyc % 3 == 1));
        pix_data  = pix_at(src_idx);
        pix_last  = (src_idx == src_len - 1);
        took      = pix_valid && pix_ready;
    end

    // ---------------- capture and expectations ----------------
    logic [7:0] lg_d [256];
    logic       lg_e [256];
    logic       lg_h [256];
    logic       lg_v [256];
    int         ncap;
    logic [7:0] ex [64];
    int         nex;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic start(input logic [1:0] f, input bit sw, input bit emb,
                         input bit strm, input bit stl, input int len);
        @(negedge clk);
        #1;
        rst_n = 1'b0; src_on = 1'b0;
        cfg_fmt = f; cfg_swap = sw; cfg_embed = emb; cfg_stream = strm;
        stall_en = stl; src_len = len;
        repeat (3) @(negedge clk);
        #1;
        rst_n = 1'b1; src_on = 1'b1;
        nex = 0;
    endtask

    task automatic cap(input int n);
        ncap = n;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            lg_d[i] = vid_data; lg_e[i] = vid_en; lg_h[i] = vid_hs; lg_v[i] = vid_vs;
        end
    endtask

    task automatic push(input logic [7:0] b);
        ex[nex] = b;
        nex++;
    endtask

    function automatic logic [7:0] xy(input bit v, input bit h);
        return {1'b1, 1'b0, v, h, v ^ h, h, v, v ^ h};
    endfunction

    task automatic push_code(input bit v, input bit h);
        push(8'hFF); push(8'h00); push(8'h00); push(xy(v, h));
    endtask

    task automatic push_pix(input logic [1:0] f, input bit sw, input int first, input int n);
        for (int i = first; i < first + n; i++) begin
            logic [23:0] p;
            logic [15:0] w;
            p = pix_at(i);
            case (f)
                2'd0: begin push(p[15:8]); push(p[7:0]); end
                2'd3: push({p[23:21], p[15:13], p[7:6]});
                default: begin
                    if (f == 2'd1) w = {p[23:19], p[15:10], p[7:3]};
                    else           w = {4'h0, p[23:20], p[15:12], p[7:4]};
                    if (sw) begin push(w[15:8]); push(w[7:0]); end
                    else    begin push(w[7:0]);  push(w[15:8]); end
                end
            endcase
        end
    endtask

    task automatic cmp_bytes(input string req);
        int k = 0, bad = -1;
        logic [7:0] a = 8'h0, e = 8'h0;
        for (int i = 0; i < ncap; i++) begin
            if (lg_e[i] && k < nex) begin
                if (lg_d[i] !== ex[k] && bad < 0) begin
                    bad = k; a = lg_d[i]; e = ex[k];
                end
                k++;
            end
        end
        chk(bad < 0, req, int'(a), int'(e));
        chk(k == nex, {req, " byte count"}, k, nex);
    endtask

    task automatic blank_chk(input string req);
        int bad = 0;
        for (int i = 0; i < ncap; i++)
            if (!lg_e[i] && lg_d[i] !== BLANK) bad++;
        chk(bad == 0, req, bad, 0);
    endtask

    // measure the first hsync run: length and qualified bytes inside it
    task automatic first_run(output int lead, output int len, output int nen, output int vlow);
        int i = 0;
        lead = 0; len = 0; nen = 0; vlow = 0;
        while (i < ncap && !lg_v[i]) begin vlow++; i++; end
        while (i < ncap && !lg_h[i]) begin lead++; i++; end
        while (i < ncap && lg_h[i]) begin len++; if (lg_e[i]) nen++; i++; end
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset;
        @(negedge clk);
        #1 rst_n = 1'b0;
        repeat (2) @(negedge clk);
        // R11
        chk(vid_en == 1'b0 && vid_hs == 1'b0 && vid_vs == 1'b0, "R11 controls in reset",
            {vid_en, vid_hs, vid_vs}, 0);
        chk(vid_data == BLANK, "R11 data in reset", vid_data, BLANK);
    endtask

    task automatic t_rgb565_sep;
        int lead, len, nen, vlow, bad;
        start(2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1000000);
        push_pix(2'd1, 1'b0, 0, 2 * NPIX);
        cap(60);
        cmp_bytes("R2 565 little-endian bytes");
        first_run(lead, len, nen, vlow);
        chk(vlow == HB + 1, "R5 vsync low over blanking line", vlow, HB + 1);
        chk(lead == HB, "R9 blanking before first pixel", lead, HB);
        chk(len == 2 * NPIX && nen == 2 * NPIX, "R9 pixel area width", nen, 2 * NPIX);
        bad = 0;
        for (int i = 0; i < ncap; i++) if (lg_e[i] && !lg_h[i]) bad++;
        chk(bad == 0, "R5 qualified byte outside hsync", bad, 0);
        blank_chk("R7 blank value in separate mode");
    endtask

    task automatic t_uyvy_embed;
        int bad = 0;
        start(2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1000000);
        push_code(1'b1, 1'b0); push_code(1'b1, 1'b1);
        push_code(1'b0, 1'b0); push_pix(2'd0, 1'b0, 0, NPIX); push_code(1'b0, 1'b1);
        push_code(1'b0, 1'b0); push_pix(2'd0, 1'b0, NPIX, NPIX); push_code(1'b0, 1'b1);
        cap(80);
        cmp_bytes("R6 R1 embedded frame bytes");
        for (int i = 0; i < ncap; i++) if (lg_h[i] || lg_v[i]) bad++;
        chk(bad == 0, "R6 sync outputs quiet", bad, 0);
        blank_chk("R7 blank value in embedded mode");
    endtask

    task automatic t_rgb444_swap;
        start(2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1000000);
        push_pix(2'd2, 1'b1, 0, 2 * NPIX);
        cap(60);
        cmp_bytes("R3 R2 444 swapped bytes");
    endtask

    task automatic t_rgb332_stall;
        int lead, len, nen, vlow;
        start(2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 1000000);
        push_pix(2'd3, 1'b0, 0, 2 * NPIX);
        cap(60);
        cmp_bytes("R4 R10 332 bytes under stall");
        first_run(lead, len, nen, vlow);
        chk(nen == NPIX, "R10 pixels per line under stall", nen, NPIX);
        chk(len > NPIX, "R10 stall stretched line", len, NPIX + 1);
        blank_chk("R7 blank value during stall");
    endtask

    task automatic t_stream;
        int first_h = -1, last_e = -1, bad = 0;
        start(2'd1, 1'b0, 1'b0, 1'b1, 1'b1, 6);
        for (int i = 0; i < 6; i++) push(pix_at(i)[7:0]);
        cap(40);
        cmp_bytes("R8 stream bytes");
        for (int i = 0; i < ncap; i++) begin
            if (lg_h[i] !== lg_v[i]) bad++;
            if (lg_h[i] && first_h < 0) first_h = i;
            if (lg_e[i]) last_e = i;
        end
        chk(bad == 0, "R8 hsync and vsync together", bad, 0);
        chk(first_h >= 0 && lg_e[first_h], "R8 syncs rise with first byte", first_h, 1);
        chk(last_e >= 0 && last_e + 1 < ncap && lg_h[last_e] && !lg_h[last_e + 1],
            "R8 syncs drop after last byte", last_e, 1);
        blank_chk("R7 blank value in stream mode");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_rgb565_sep();
        t_uyvy_embed();
        t_rgb444_swap();
        t_rgb332_stall();
        t_stream();
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule